// File: doc/BRIEF.md
# Dual-Edge Retriggerable One-Shot Timer

This block is a clocked, fully digital monostable. Each channel watches two trigger lines, one active on its rising edge and one active on its falling edge, and answers a qualified edge with a single output pulse. The pulse width is a programmable number of clock cycles. Both trigger lines are brought into the clock domain by two-flop synchronisers. An edge on either line counts only while the other line sits at its idle level. The pulse drives a pair of complementary outputs.

A per-channel mode input selects how the block treats triggers that arrive while a pulse is running. In retrigger mode such a trigger restarts the count, so the pulse ends one period after the last trigger. In first-trigger mode such a trigger is ignored. A per-channel active-low clear ends a running pulse on the next clock edge and keeps the channel quiet while it is held low. The top module is a bank of identical, independent channels; the default bank has two.

Top module: `oneshot_bank`

## Requirements
- R1: After the system reset every channel has its pulse output at 0 and its inverted output at 1.
- R2: With the negative-edge trigger input held high, a rising edge on the positive-edge trigger input starts a pulse. The pulse output rises on the third rising clock edge after the input changes.
- R3: With the positive-edge trigger input held low, a falling edge on the negative-edge trigger input starts a pulse with the same three-cycle latency.
- R4: A rising edge on the positive-edge trigger input while the negative-edge input is low starts no pulse. A falling edge on the negative-edge trigger input while the positive-edge input is high starts no pulse.
- R5: With a period value N of 1 or more, the pulse output stays high for exactly N clock cycles.
- R6: With the mode input at 1 (retrigger mode), a qualified trigger that lands during a pulse reloads the count. The pulse then ends N cycles after that trigger takes effect.
- R7: With the mode input at 0 (first-trigger mode), triggers that land while the pulse output is high are ignored. The pulse ends N cycles after the first trigger.
- R8: When the active-low clear is sampled low, the pulse output is 0 from the next clock edge on. No pulse starts while the clear stays low.
- R9: A trigger that would take effect on the first clock edge at which the clear is sampled high again is ignored.
- R10: A period value of 0 suppresses pulses: a trigger then neither starts nor restarts a pulse.
- R11: The period value is captured only when a pulse starts or restarts. Changing it during a pulse does not change when that pulse ends.
- R12: The inverted output is always the complement of the pulse output.
- R13: Channels are independent: the triggers, clear, mode and period of one channel have no effect on any other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| sys_rst_ni | input | 1 | Asynchronous active-low system reset |
| trig_pos_i | input | CHANNELS | Positive-edge trigger, one bit per channel, idle low |
| trig_neg_i | input | CHANNELS | Negative-edge trigger, one bit per channel, idle high |
| clr_ni | input | CHANNELS | Active-low pulse clear, one bit per channel |
| retrig_i | input | CHANNELS | Mode per channel: 1 retrigger, 0 first-trigger only |
| period_i | input | CHANNELS*PERIOD_W | Period in clock cycles per channel; channel c uses bits [c*PERIOD_W +: PERIOD_W] |
| q_o | output | CHANNELS | Pulse output per channel |
| qn_o | output | CHANNELS | Inverted pulse output per channel |

## Verification
The bound checker enforces four rules on every cycle and for every channel. The two outputs stay complementary. A low clear forces the pulse output off on the next edge. An idle channel with a zero period stays idle. A pulse only rises after the clear has been high for two sampled edges. The exact three-cycle trigger latency, the exact pulse length, the extension in retrigger mode against the fixed end in first-trigger mode, edge qualification and the capture of the period at start are shown only by the bench's directed scenarios, which count cycles from each stimulus.

// File: rtl/oneshot_pkg.sv
`timescale 1ns/1ps
package oneshot_pkg;

    // Synchronised trigger levels of one channel.
    typedef struct packed {
        logic pos;
        logic neg;
    } trig_pair_t;

    // Idle level of the pair: positive line low, negative line high.
    localparam trig_pair_t TRIG_IDLE = '{pos: 1'b0, neg: 1'b1};

endpackage

// File: rtl/os_sync.sv
`timescale 1ns/1ps
module os_sync #(
    parameter int          WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.meta   <= RST_VAL;
            st_q.stable <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stable;

endmodule

// File: rtl/os_edge_qual.sv
`timescale 1ns/1ps
module os_edge_qual
    import oneshot_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  trig_pair_t level_i,
    output logic       fire_o
);

    typedef struct packed {
        trig_pair_t prev;
    } qual_state_t;

    qual_state_t st_d, st_q;
    logic        pos_rise;
    logic        neg_fall;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        // Each edge counts only while the opposite line is at its idle level.
        pos_rise  = level_i.pos && !st_q.prev.pos && level_i.neg;
        neg_fall  = !level_i.neg && st_q.prev.neg && !level_i.pos;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.prev <= TRIG_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_o = pos_rise || neg_fall;

endmodule

// File: rtl/os_timer.sv
`timescale 1ns/1ps
module os_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                fire_i,
    input  logic                clr_ni,
    input  logic                retrig_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                q_o,
    output logic                qn_o
);

    localparam logic [PERIOD_W-1:0] CNT_ONE = PERIOD_W'(1);

    typedef struct packed {
        logic                armed;
        logic                q;
        logic                qn;
        logic [PERIOD_W-1:0] cnt;
    } timer_state_t;

    timer_state_t st_d, st_q;
    logic         accept;

    always_comb begin
        st_d       = st_q;
        st_d.armed = clr_ni;
        accept     = 1'b0;
        if (!clr_ni) begin
            st_d.q   = 1'b0;
            st_d.cnt = '0;
        end else begin
            accept = fire_i && st_q.armed && (period_i != '0)
                     && (!st_q.q || retrig_i);
            if (accept) begin
                st_d.q   = 1'b1;
                st_d.cnt = period_i;
            end else if (st_q.q) begin
                if (st_q.cnt == CNT_ONE) begin
                    st_d.q   = 1'b0;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_ONE;
                end
            end
        end
        st_d.qn = !st_d.q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.armed <= 1'b0;
            st_q.q     <= 1'b0;
            st_q.qn    <= 1'b1;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o  = st_q.q;
    assign qn_o = st_q.qn;

endmodule

// File: rtl/os_channel.sv
`timescale 1ns/1ps
module os_channel
    import oneshot_pkg::*;
#(
    parameter int PERIOD_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                trig_pos_i,
    input  logic                trig_neg_i,
    input  logic                clr_ni,
    input  logic                retrig_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                q_o,
    output logic                qn_o
);

    localparam int SYNC_W = $bits(trig_pair_t);

    trig_pair_t raw;
    trig_pair_t synced;
    logic       fire;

    assign raw.pos = trig_pos_i;
    assign raw.neg = trig_neg_i;

    os_sync #(
        .WIDTH   (SYNC_W),
        .RST_VAL (TRIG_IDLE)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw),
        .sync_o  (synced)
    );

    os_edge_qual i_qual (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (synced),
        .fire_o  (fire)
    );

    os_timer #(
        .PERIOD_W (PERIOD_W)
    ) i_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .fire_i   (fire),
        .clr_ni   (clr_ni),
        .retrig_i (retrig_i),
        .period_i (period_i),
        .q_o      (q_o),
        .qn_o     (qn_o)
    );

endmodule

// File: rtl/oneshot_bank.sv
`timescale 1ns/1ps
module oneshot_bank #(
    parameter int CHANNELS = 2,
    parameter int PERIOD_W = 16
) (
    input  logic                         clk_i,
    input  logic                         sys_rst_ni,
    input  logic [CHANNELS-1:0]          trig_pos_i,
    input  logic [CHANNELS-1:0]          trig_neg_i,
    input  logic [CHANNELS-1:0]          clr_ni,
    input  logic [CHANNELS-1:0]          retrig_i,
    input  logic [CHANNELS*PERIOD_W-1:0] period_i,
    output logic [CHANNELS-1:0]          q_o,
    output logic [CHANNELS-1:0]          qn_o
);

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        os_channel #(
            .PERIOD_W (PERIOD_W)
        ) i_channel (
            .clk_i      (clk_i),
            .rst_ni     (sys_rst_ni),
            .trig_pos_i (trig_pos_i[c]),
            .trig_neg_i (trig_neg_i[c]),
            .clr_ni     (clr_ni[c]),
            .retrig_i   (retrig_i[c]),
            .period_i   (period_i[c*PERIOD_W +: PERIOD_W]),
            .q_o        (q_o[c]),
            .qn_o       (qn_o[c])
        );
    end

endmodule

// File: rtl/oneshot_bank_chk.sv
`timescale 1ns/1ps
module oneshot_bank_chk #(
    parameter int CHANNELS = 2,
    parameter int PERIOD_W = 16
) (
    input logic                         clk_i,
    input logic                         sys_rst_ni,
    input logic [CHANNELS-1:0]          clr_ni,
    input logic [CHANNELS*PERIOD_W-1:0] period_i,
    input logic [CHANNELS-1:0]          q_o,
    input logic [CHANNELS-1:0]          qn_o
);

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chk
        p_complement_r12: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
            q_o[c] != qn_o[c]);

        p_clear_ends_r8: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
            !clr_ni[c] |=> !q_o[c]);

        p_zero_period_r10: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
            (!q_o[c] && (period_i[c*PERIOD_W +: PERIOD_W] == '0)) |=> !q_o[c]);

        p_start_after_release_r9: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
            $rose(q_o[c]) |-> ($past(clr_ni[c]) && $past(clr_ni[c], 2)));
    end

endmodule

bind oneshot_bank oneshot_bank_chk #(
    .CHANNELS (CHANNELS),
    .PERIOD_W (PERIOD_W)
) i_chk (
    .clk_i      (clk_i),
    .sys_rst_ni (sys_rst_ni),
    .clr_ni     (clr_ni),
    .period_i   (period_i),
    .q_o        (q_o),
    .qn_o       (qn_o)
);

// File: tb/test_oneshot_bank.sv
`timescale 1ns/1ps
module test_oneshot_bank;

    localparam int CH = 2;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          sys_rst_n = 1'b0;
    logic [CH-1:0] trig_pos = '0;
    logic [CH-1:0] trig_neg = '1;
    logic [CH-1:0] clr_n = '1;
    logic [CH-1:0] retrig = '1;
    logic [PW-1:0] per [CH];
    logic [CH*PW-1:0] period_flat;
    logic [CH-1:0] q;
    logic [CH-1:0] qn;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    assign period_flat = {per[1], per[0]};

    always #2 clk = !clk;

    oneshot_bank #(
        .CHANNELS (CH),
        .PERIOD_W (PW)
    ) i_oneshot_bank (
        .clk_i      (clk),
        .sys_rst_ni (sys_rst_n),
        .trig_pos_i (trig_pos),
        .trig_neg_i (trig_neg),
        .clr_ni     (clr_n),
        .retrig_i   (retrig),
        .period_i   (period_flat),
        .q_o        (q),
        .qn_o       (qn)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        trig_pos = '0;
        trig_neg = '1;
        clr_n    = '1;
        step(12);
    endtask

    // Trigger already driven at the current falling edge; follow the pulse.
    task automatic expect_pulse(input int ch, input int n, input string tag);
        step(2);
        chk(q[ch], 1'b0, {tag, " output still low before latency"});
        step(1);
        chk(q[ch], 1'b1, {tag, " output high on third edge"});
        chk(qn[ch], 1'b0, "R12 inverted output low during pulse");
        step(n - 1);
        chk(q[ch], 1'b1, {tag, " R5 output high on last cycle"});
        step(1);
        chk(q[ch], 1'b0, {tag, " R5 output low after N cycles"});
        chk(qn[ch], 1'b1, "R12 inverted output high after pulse");
    endtask

    task automatic t_reset();
        chk(q[0], 1'b0, "R1 reset q ch0");
        chk(q[1], 1'b0, "R1 reset q ch1");
        chk(qn[0], 1'b1, "R1 reset qn ch0");
        chk(qn[1], 1'b1, "R1 reset qn ch1");
    endtask

    task automatic t_pos_edge();
        per[0] = 16'd5;
        retrig[0] = 1'b1;
        @(negedge clk);
        trig_pos[0] = 1'b1;
        expect_pulse(0, 5, "R2");
        settle();
    endtask

    task automatic t_neg_edge();
        per[0] = 16'd3;
        @(negedge clk);
        trig_neg[0] = 1'b0;
        expect_pulse(0, 3, "R3");
        settle();
    endtask

    task automatic t_min_period();
        per[1] = 16'd1;
        @(negedge clk);
        trig_pos[1] = 1'b1;
        expect_pulse(1, 1, "R5 one-cycle");
        settle();
    endtask

    task automatic t_qualify();
        per[0] = 16'd4;
        @(negedge clk);
        trig_pos[0] = 1'b1;
        step(12);
        // positive line high: falling negative edge must not fire (R4)
        trig_neg[0] = 1'b0;
        step(3);
        chk(q[0], 1'b0, "R4 neg edge blocked while pos high");
        step(3);
        chk(q[0], 1'b0, "R4 neg edge blocked later");
        trig_pos[0] = 1'b0;
        step(6);
        // negative line low: rising positive edge must not fire (R4)
        trig_pos[0] = 1'b1;
        step(3);
        chk(q[0], 1'b0, "R4 pos edge blocked while neg low");
        step(3);
        chk(q[0], 1'b0, "R4 pos edge blocked later");
        settle();
    endtask

    task automatic t_retrigger(input logic mode, input string tag, input int fall_k);
        per[0] = 16'd10;
        retrig[0] = mode;
        @(negedge clk);
        trig_pos[0] = 1'b1;
        step(2);
        trig_pos[0] = 1'b0;
        step(2);
        trig_pos[0] = 1'b1;    // second trigger at k=4
        step(fall_k - 5);
        chk(q[0], 1'b1, {tag, " output high one cycle before expected end"});
        step(1);
        chk(q[0], 1'b0, {tag, " output low at expected end"});
        step(4);
        chk(q[0], 1'b0, {tag, " output stays low"});
        retrig[0] = 1'b1;
        settle();
    endtask

    task automatic t_clear();
        per[0] = 16'd20;
        @(negedge clk);
        trig_pos[0] = 1'b1;
        step(6);
        chk(q[0], 1'b1, "R8 pulse running before clear");
        clr_n[0] = 1'b0;
        step(1);
        chk(q[0], 1'b0, "R8 clear ends pulse on next edge");
        chk(qn[0], 1'b1, "R12 inverted output high under clear");
        trig_pos[0] = 1'b0;
        step(2);
        trig_pos[0] = 1'b1;
        step(5);
        chk(q[0], 1'b0, "R8 trigger ignored while clear low");
        settle();
    endtask

    task automatic t_release();
        per[0] = 16'd4;
        clr_n[0] = 1'b0;
        step(4);
        trig_pos[0] = 1'b1;
        step(2);
        clr_n[0] = 1'b1;       // first sampled high on the trigger's edge
        step(1);
        chk(q[0], 1'b0, "R9 trigger on release edge ignored");
        step(3);
        chk(q[0], 1'b0, "R9 still no pulse");
        trig_pos[0] = 1'b0;
        step(4);
        trig_pos[0] = 1'b1;
        step(3);
        chk(q[0], 1'b1, "R9 next trigger after release works");
        settle();
    endtask

    task automatic t_zero_period();
        per[0] = 16'd0;
        @(negedge clk);
        trig_pos[0] = 1'b1;
        step(3);
        chk(q[0], 1'b0, "R10 zero period no pulse");
        step(2);
        chk(q[0], 1'b0, "R10 zero period still no pulse");
        settle();
    endtask

    task automatic t_period_change();
        per[0] = 16'd8;
        @(negedge clk);
        trig_pos[0] = 1'b1;
        step(5);
        per[0] = 16'd3;
        step(5);
        chk(q[0], 1'b1, "R11 pulse keeps captured period");
        step(1);
        chk(q[0], 1'b0, "R11 pulse ends after captured period");
        settle();
    endtask

    task automatic t_independent();
        per[0] = 16'd6;
        per[1] = 16'd6;
        clr_n[1] = 1'b0;
        @(negedge clk);
        trig_pos[0] = 1'b1;
        trig_pos[1] = 1'b1;
        step(3);
        chk(q[0], 1'b1, "R13 ch0 pulses while ch1 cleared");
        chk(q[1], 1'b0, "R13 ch1 held by its own clear");
        step(6);
        chk(q[0], 1'b0, "R13 ch0 ends after its own period");
        settle();
        @(negedge clk);
        trig_pos[1] = 1'b1;
        step(3);
        chk(q[0], 1'b0, "R13 ch0 unaffected by ch1 trigger");
        chk(q[1], 1'b1, "R13 ch1 pulses on its own trigger");
        settle();
    endtask

    initial begin
        per[0] = 16'd5;
        per[1] = 16'd5;
        step(3);
        t_reset();
        sys_rst_n = 1'b1;
        step(4);
        t_reset();
        t_pos_edge();
        t_neg_edge();
        t_min_period();
        t_qualify();
        t_retrigger(1'b1, "R6", 17);
        t_retrigger(1'b0, "R7", 13);
        t_clear();
        t_release();
        t_zero_period();
        t_period_change();
        t_independent();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule